// File: doc/BRIEF.md
# Four-Counter Performance Monitor with Split Control Registers

This block counts hardware activity for a processor core. It holds one 32-bit cycle counter and four 32-bit event counters. Each event counter has its own 8-bit code that picks one line of an indexed event pulse bus. The counter adds one on every clock in which that line is high and counting is on. Any counter that wraps past its all-ones value raises a sticky overflow flag. One level interrupt line goes high while an enabled flag is set.

Software programs the block through a simple single-cycle register port. Each kind of control has its own register. The control register holds the global run bit, two self-clearing reset strobes and a divide-by-64 cycle mode. The interrupt-enable register and the overflow-flag register use one bit per counter. The event-select register packs the four codes. The five counters are read and written directly at their own addresses. Reads are combinational from the current address. Writes take effect at the next rising clock edge.

Top module: `perfMonSplit`

## Requirements
- R1: After reset, the control, interrupt-enable and overflow-flag registers and all five counters read zero. The event-select register reads 0xFFFFFFFF, so every event counter is off. The interrupt line is low.
- R2: Control register (address 0) bit meanings: bit 0 is run, bit 1 clears the event counters, bit 2 clears the cycle counter, bit 3 selects divided cycle mode. Only bits 0 and 3 are stored. A read of address 0 returns run in bit 0, divided mode in bit 3, and zero in every other bit, whatever was written to bits 31:4.
- R3: While run is 0, no counter changes, except through a direct write or a reset strobe.
- R4: Event-select register (address 3) layout: counter 0 code in bits 7:0, counter 1 in bits 15:8, counter 2 in bits 23:16, counter 3 in bits 31:24. While running, an event counter adds one on each clock in which event line number `code` is high. Code 0xFF, and any code at or above the number of event lines (32), never counts.
- R5: While running, the cycle counter adds one every clock. In divided mode it adds one on every 64th running clock, counted from the last cycle-counter clear.
- R6: Writing 1 to control bit 1 clears all four event counters. Writing 1 to control bit 2 clears the cycle counter and the divide prescaler. Neither bit is stored, and neither strobe touches the other group of counters.
- R7: Counters are read and written directly: the cycle counter at address 4, event counters 0 to 3 at addresses 5 to 8.
- R8: A counter that steps from 0xFFFFFFFF to 0 sets its flag in the overflow-flag register (address 2) on that same edge. Bit 0 is the cycle counter; bits 1 to 4 are event counters 0 to 3. Loading a value never sets a flag.
- R9: Writing a 1 to a bit of the overflow-flag register clears that flag. Writing a 0 leaves it unchanged.
- R10: When a software clear and a new wrap of the same counter fall on the same edge, the flag ends up set.
- R11: The interrupt-enable register (address 1) uses the same bit layout as the flags. The interrupt output is high exactly while some flag and its enable bit are both 1.
- R12: Addresses 9 and above read zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| evtIn | input | EVT_LINES | Indexed event pulse lines, one per event number |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | ADDR_W | Register address |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for regAddr |
| irq | output | 1 | Level interrupt: an enabled overflow flag is set |

## Verification
Counting is tried three ways:
- With event lines held high across runs of several lengths, which separates counting on every edge from counting per pulse.
- With one line per pattern and then all lines at once, which separates the decoding of each select byte from its neighbours, and shows that out-of-range and 0xFF codes stay silent.
- With divided mode over 201 running clocks, which gives 3 only if the prescaler restarts on clear and wraps at 64.

Wrap tests preload 0xFFFFFFFD and 0xFFFFFFFF and step them one edge at a time, so the flag is seen to rise on the wrap edge and not before. A wrap placed on the same edge as a clear write shows which of the two wins the flag.

// File: rtl/perfMonPkg.sv
package perfMonPkg;
  localparam int DATA_W  = 32;
  localparam int CNT_W   = 32;
  localparam int NUM_EVT = 4;
  localparam int CODE_W  = 8;
  localparam int SEL_W   = NUM_EVT * CODE_W;
  localparam int FLAG_W  = NUM_EVT + 1;

  localparam int ADDR_CTRL = 0;
  localparam int ADDR_IEN  = 1;
  localparam int ADDR_OVF  = 2;
  localparam int ADDR_SEL  = 3;
  localparam int ADDR_CYC  = 4;
  localparam int ADDR_EVT0 = 5;
  localparam int ADDR_LAST = ADDR_EVT0 + NUM_EVT - 1;

  localparam int CTRL_RUN    = 0;
  localparam int CTRL_RSTEVT = 1;
  localparam int CTRL_RSTCYC = 2;
  localparam int CTRL_DIV    = 3;

  localparam logic [CODE_W-1:0] CODE_OFF = '1;

  // strobes from control to datapath, valid for one cycle
  typedef struct packed {
    logic [NUM_EVT-1:0] wrEvt;
    logic               wrCyc;
    logic               rstEvt;
    logic               rstCyc;
    logic [CNT_W-1:0]   wrData;
  } pmStrobe_t;

  // static configuration held by control
  typedef struct packed {
    logic             run;
    logic             divMode;
    logic [SEL_W-1:0] evtSel;
  } pmCfg_t;
endpackage

// File: rtl/perfMonSlice.sv
module perfMonSlice #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         clr,
  input  logic         load,
  input  logic [W-1:0] loadVal,
  input  logic         inc,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     cnt <= '0;
    else if (clr)  cnt <= '0;
    else if (load) cnt <= loadVal;
    else if (inc)  cnt <= cnt + 1'b1;
  end

  assign wrap = inc && !clr && !load && (cnt == '1);

  assert_wrap_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
    wrap |=> (cnt == '0));

  assert_clr_zero_R6: assert property (@(posedge clk) disable iff (!rstN)
    clr |=> (cnt == '0));
endmodule

// File: rtl/perfMonPath.sv
module perfMonPath
  import perfMonPkg::*;
#(
  parameter int EVT_LINES = 32,
  parameter int DIV_LOG2  = 6
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  pmStrobe_t                     strb,
  input  pmCfg_t                        cfg,
  input  logic [EVT_LINES-1:0]          evtIn,
  output logic [CNT_W-1:0]              cycVal,
  output logic [NUM_EVT-1:0][CNT_W-1:0] evtVal,
  output logic [FLAG_W-1:0]             wrapPulse
);
  localparam int LINE_W = (EVT_LINES > 1) ? $clog2(EVT_LINES) : 1;

  logic [DIV_LOG2-1:0] preQ;
  logic                cycInc;

  // prescaler for divided cycle mode
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                        preQ <= '0;
    else if (strb.rstCyc)             preQ <= '0;
    else if (cfg.run && cfg.divMode)  preQ <= preQ + 1'b1;
  end

  assign cycInc = cfg.run && (!cfg.divMode || (preQ == '1));

  perfMonSlice #(.W(CNT_W)) u_cycSlice (
    .clk    (clk),
    .rstN   (rstN),
    .clr    (strb.rstCyc),
    .load   (strb.wrCyc),
    .loadVal(strb.wrData),
    .inc    (cycInc),
    .cnt    (cycVal),
    .wrap   (wrapPulse[0])
  );

  assert_stop_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!cfg.run && !strb.rstCyc && !strb.wrCyc) |=> $stable(cycVal));

  for (genvar g = 0; g < NUM_EVT; g++) begin : gEvt
    logic [CODE_W-1:0] code;
    logic              hit;

    assign code = cfg.evtSel[g*CODE_W +: CODE_W];
    assign hit  = (code != CODE_OFF) && (int'(code) < EVT_LINES)
                  && evtIn[code[LINE_W-1:0]];

    perfMonSlice #(.W(CNT_W)) u_evtSlice (
      .clk    (clk),
      .rstN   (rstN),
      .clr    (strb.rstEvt),
      .load   (strb.wrEvt[g]),
      .loadVal(strb.wrData),
      .inc    (cfg.run && hit),
      .cnt    (evtVal[g]),
      .wrap   (wrapPulse[g+1])
    );

    assert_off_code_R4: assert property (@(posedge clk) disable iff (!rstN)
      ((code == CODE_OFF) && !strb.rstEvt && !strb.wrEvt[g]) |=> $stable(evtVal[g]));
  end
endmodule

// File: rtl/perfMonCtrl.sv
module perfMonCtrl
  import perfMonPkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          regWrEn,
  input  logic [ADDR_W-1:0]             regAddr,
  input  logic [DATA_W-1:0]             regWrData,
  output logic [DATA_W-1:0]             regRdData,
  output logic                          irq,
  input  logic [CNT_W-1:0]              cycVal,
  input  logic [NUM_EVT-1:0][CNT_W-1:0] evtVal,
  input  logic [FLAG_W-1:0]             wrapPulse,
  output pmStrobe_t                     strb,
  output pmCfg_t                        cfg
);
  logic              runQ, divQ;
  logic [FLAG_W-1:0] ienQ, ovfQ, ovfNext, clrMask;
  logic [SEL_W-1:0]  selQ;
  logic              wrCtrl, wrIen, wrOvf, wrSel;

  assign wrCtrl = regWrEn && (regAddr == ADDR_W'(ADDR_CTRL));
  assign wrIen  = regWrEn && (regAddr == ADDR_W'(ADDR_IEN));
  assign wrOvf  = regWrEn && (regAddr == ADDR_W'(ADDR_OVF));
  assign wrSel  = regWrEn && (regAddr == ADDR_W'(ADDR_SEL));

  // new wraps win over a same-edge clear
  assign clrMask = wrOvf ? regWrData[FLAG_W-1:0] : '0;
  assign ovfNext = (ovfQ & ~clrMask) | wrapPulse;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runQ <= 1'b0;
      divQ <= 1'b0;
      ienQ <= '0;
      ovfQ <= '0;
      selQ <= '1;
    end else begin
      if (wrCtrl) begin
        runQ <= regWrData[CTRL_RUN];
        divQ <= regWrData[CTRL_DIV];
      end
      if (wrIen) ienQ <= regWrData[FLAG_W-1:0];
      if (wrSel) selQ <= regWrData[SEL_W-1:0];
      ovfQ <= ovfNext;
    end
  end

  always_comb begin
    strb.rstEvt = wrCtrl && regWrData[CTRL_RSTEVT];
    strb.rstCyc = wrCtrl && regWrData[CTRL_RSTCYC];
    strb.wrCyc  = regWrEn && (regAddr == ADDR_W'(ADDR_CYC));
    strb.wrData = regWrData[CNT_W-1:0];
    for (int i = 0; i < NUM_EVT; i++)
      strb.wrEvt[i] = regWrEn && (regAddr == ADDR_W'(ADDR_EVT0 + i));
  end

  assign cfg.run     = runQ;
  assign cfg.divMode = divQ;
  assign cfg.evtSel  = selQ;

  always_comb begin
    regRdData = '0;
    if (regAddr == ADDR_W'(ADDR_CTRL)) begin
      regRdData[CTRL_RUN] = runQ;
      regRdData[CTRL_DIV] = divQ;
    end else if (regAddr == ADDR_W'(ADDR_IEN)) begin
      regRdData[FLAG_W-1:0] = ienQ;
    end else if (regAddr == ADDR_W'(ADDR_OVF)) begin
      regRdData[FLAG_W-1:0] = ovfQ;
    end else if (regAddr == ADDR_W'(ADDR_SEL)) begin
      regRdData[SEL_W-1:0] = selQ;
    end else if (regAddr == ADDR_W'(ADDR_CYC)) begin
      regRdData[CNT_W-1:0] = cycVal;
    end
    for (int i = 0; i < NUM_EVT; i++)
      if (regAddr == ADDR_W'(ADDR_EVT0 + i)) regRdData[CNT_W-1:0] = evtVal[i];
  end

  assign irq = |(ovfQ & ienQ);

  assert_ctrl_rd_R2: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == ADDR_W'(ADDR_CTRL)) |->
      ((regRdData[DATA_W-1:CTRL_DIV+1] == '0) && (regRdData[CTRL_RSTCYC:CTRL_RSTEVT] == '0)));

  assert_flag_set_R8: assert property (@(posedge clk) disable iff (!rstN)
    (wrapPulse != '0) |=> ((ovfQ & $past(wrapPulse)) == $past(wrapPulse)));

  assert_w1c_R9: assert property (@(posedge clk) disable iff (!rstN)
    (wrOvf && (wrapPulse == '0)) |=> ((ovfQ & $past(regWrData[FLAG_W-1:0])) == '0));

  assert_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    !wrOvf |=> ((ovfQ & $past(ovfQ)) == $past(ovfQ)));

  assert_irq_quiet_R11: assert property (@(posedge clk) disable iff (!rstN)
    ((ienQ == '0) || (ovfQ == '0)) |-> !irq);

  assert_unmapped_R12: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr > ADDR_W'(ADDR_LAST)) |-> (regRdData == '0));
endmodule

// File: rtl/perfMonSplit.sv
module perfMonSplit
  import perfMonPkg::*;
#(
  parameter int EVT_LINES = 32,
  parameter int DIV_LOG2  = 6,
  parameter int ADDR_W    = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [EVT_LINES-1:0] evtIn,
  input  logic                 regWrEn,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [DATA_W-1:0]    regWrData,
  output logic [DATA_W-1:0]    regRdData,
  output logic                 irq
);
  pmStrobe_t                     strb;
  pmCfg_t                        cfg;
  logic [CNT_W-1:0]              cycVal;
  logic [NUM_EVT-1:0][CNT_W-1:0] evtVal;
  logic [FLAG_W-1:0]             wrapPulse;

  perfMonCtrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .regWrEn  (regWrEn),
    .regAddr  (regAddr),
    .regWrData(regWrData),
    .regRdData(regRdData),
    .irq      (irq),
    .cycVal   (cycVal),
    .evtVal   (evtVal),
    .wrapPulse(wrapPulse),
    .strb     (strb),
    .cfg      (cfg)
  );

  perfMonPath #(.EVT_LINES(EVT_LINES), .DIV_LOG2(DIV_LOG2)) u_path (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .cfg      (cfg),
    .evtIn    (evtIn),
    .cycVal   (cycVal),
    .evtVal   (evtVal),
    .wrapPulse(wrapPulse)
  );
endmodule

// File: tb/perfMonSplit_bench.sv
module perfMonSplit_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] evtIn = '0;
  logic        regWrEn = 1'b0;
  logic [3:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        irq;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [31:0] expQ[$];
  bit          kindQ[$];
  string       tagQ[$];

  always #4 clk = ~clk;

  perfMonSplit u_perfMonSplit (
    .clk(clk), .rstN(rstN), .evtIn(evtIn), .regWrEn(regWrEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData), .irq(irq)
  );

  task automatic regWrite(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(posedge clk); #1;
    regWrEn = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pulseRun(input logic [31:0] mask, input int n);
    for (int i = 0; i < n; i++) begin
      evtIn = mask;
      @(posedge clk); #1;
    end
  endtask

  task automatic readChk(input logic [3:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    regWrEn = 1'b0; regAddr = a;
    expQ.push_back(e); kindQ.push_back(1'b0); tagQ.push_back(tag);
    @(posedge clk); #1;
  endtask

  task automatic irqChk(input logic e, input string tag);
    @(negedge clk);
    expQ.push_back({31'b0, e}); kindQ.push_back(1'b1); tagQ.push_back(tag);
    @(posedge clk); #1;
  endtask

  // monitor: pops one expectation per cycle, samples just before the rising edge
  initial forever begin
    @(negedge clk); #3;
    if (expQ.size() > 0) begin
      logic [31:0] e, act;
      bit k;
      string t;
      e = expQ.pop_front(); k = kindQ.pop_front(); t = tagQ.pop_front();
      act = k ? {31'b0, irq} : regRdData;
      total++;
      if (act !== e) begin
        bad++;
        $display("FAIL %s: actual %h expected %h", t, act, e);
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk); #1;
    rstN = 1'b1;
    // R1 reset state
    readChk(0, 32'h0, "R1 ctrl");
    readChk(1, 32'h0, "R1 ien");
    readChk(2, 32'h0, "R1 ovf");
    readChk(3, 32'hFFFF_FFFF, "R1 sel");
    for (int a = 4; a <= 8; a++) readChk(4'(a), 32'h0, "R1 counter");
    irqChk(1'b0, "R1 irq");
    // R2 masked control
    regWrite(0, 32'hFFFF_FFF8);
    readChk(0, 32'h0000_0008, "R2 masked read");
    regWrite(0, 32'h0);
    readChk(0, 32'h0, "R2 cleared");
    // R7 direct counter access
    regWrite(4, 32'h1234_5678);
    regWrite(6, 32'hA5A5_0F0F);
    readChk(4, 32'h1234_5678, "R7 cycle load");
    readChk(6, 32'hA5A5_0F0F, "R7 evt1 load");
    // R12 unmapped
    regWrite(9, 32'hFFFF_FFFF);
    readChk(9, 32'h0, "R12 read zero");
    readChk(1, 32'h0, "R12 ien untouched");
    // R3 stopped
    idle(10);
    readChk(4, 32'h1234_5678, "R3 cycle held");
    readChk(6, 32'hA5A5_0F0F, "R3 evt held");
    // R5 plain cycle counting: 20 idle + disabling edge
    regWrite(0, 32'h5);
    idle(20);
    regWrite(0, 32'h0);
    readChk(4, 32'd21, "R5 cycle count");
    // R5 divided: 201 running edges / 64 = 3
    regWrite(0, 32'hD);
    idle(200);
    regWrite(0, 32'h0);
    readChk(4, 32'd3, "R5 divided count");
    // R6 reset strobes
    regWrite(0, 32'h2);
    readChk(6, 32'h0, "R6 evt cleared");
    readChk(4, 32'd3, "R6 cycle kept");
    readChk(0, 32'h0, "R6 strobe not stored");
    regWrite(0, 32'h4);
    readChk(4, 32'h0, "R6 cycle cleared");
    // R4 event select
    regWrite(3, 32'hFF40_0702);
    readChk(3, 32'hFF40_0702, "R4 sel readback");
    regWrite(0, 32'h3);
    pulseRun(32'h0000_0004, 5);
    pulseRun(32'h0000_0080, 3);
    pulseRun(32'hFFFF_FFFF, 4);
    evtIn = '0;
    idle(2);
    regWrite(0, 32'h0);
    readChk(5, 32'd9, "R4 code 2");
    readChk(6, 32'd7, "R4 code 7");
    readChk(7, 32'd0, "R4 code out of range");
    readChk(8, 32'd0, "R4 code FF");
    readChk(2, 32'h0, "R8 no flag");
    // R8 cycle wrap
    regWrite(4, 32'hFFFF_FFFD);
    regWrite(0, 32'h1);
    idle(1);
    regWrite(0, 32'h0);
    readChk(4, 32'hFFFF_FFFF, "R8 before wrap");
    readChk(2, 32'h0, "R8 no early flag");
    regWrite(0, 32'h1);
    regWrite(0, 32'h0);
    readChk(4, 32'h0, "R8 cycle wrapped");
    readChk(2, 32'h1, "R8 cycle flag");
    irqChk(1'b0, "R11 no enable");
    // R8 event wrap on counter 2
    regWrite(7, 32'hFFFF_FFFF);
    regWrite(3, 32'hFF05_0702);
    regWrite(0, 32'h1);
    pulseRun(32'h0000_0020, 1);
    evtIn = '0;
    regWrite(0, 32'h0);
    readChk(7, 32'h0, "R8 evt2 wrapped");
    readChk(2, 32'h9, "R8 evt2 flag");
    // R11 interrupt
    regWrite(1, 32'h08);
    irqChk(1'b1, "R11 enabled flag");
    regWrite(1, 32'h10);
    irqChk(1'b0, "R11 other enable");
    regWrite(1, 32'h18);
    irqChk(1'b1, "R11 mixed");
    // R9 write-one-to-clear
    regWrite(2, 32'h0);
    readChk(2, 32'h9, "R9 zero write");
    regWrite(2, 32'h1);
    readChk(2, 32'h8, "R9 clear bit0");
    irqChk(1'b1, "R11 still set");
    regWrite(2, 32'h8);
    readChk(2, 32'h0, "R9 clear bit3");
    irqChk(1'b0, "R11 dropped");
    // R10 set beats clear
    regWrite(5, 32'hFFFF_FFFF);
    regWrite(0, 32'h1);
    evtIn = 32'h0000_0004;
    regWrite(2, 32'h2);
    evtIn = '0;
    regWrite(0, 32'h0);
    readChk(5, 32'h0, "R10 evt0 wrapped");
    readChk(2, 32'h2, "R10 flag survives clear");
    idle(2);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule